// File: doc/BRIEF.md
# Key-Input Interrupt Unit

This block watches a small group of key or switch inputs and raises one shared interrupt when any input that software has enabled goes high. Software reaches it through three 4-bit registers on a simple synchronous bus with an address, a write strobe and a read strobe. The first register returns the present input levels. The second holds one enable bit per input. The third holds the shared interrupt flag, and reading that register clears the flag.

An edge detector works on each input ANDed with its enable bit, so the flag is set in two cases: when an enabled input rises, and when an enable bit is switched on while its input is already high. A parameter can place a debounce filter in front of the detector. With the filter in place, a level change only reaches the detector after it has held steady for a set number of clocks, so short glitches never set the flag. The interrupt request output follows the flag directly.

Top module: `keyirq_unit`

## Requirements
- R1: A read at address 0 returns the raw input levels on bus_rdata, with bit i equal to key_in[i] (1 = high). A write to address 0 changes nothing.
- R2: The enable register sits at address 1 and is read/write. Bit i set to 1 enables input i and 0 masks it. It resets to 0000 and changes only when address 1 is written.
- R3: The flag register sits at address 2. The flag is bit 2, and bits 3, 1 and 0 always read 0. Writes to address 2 have no effect.
- R4: The flag is set on the clock edge that follows a cycle in which some input, ANDed with its enable bit, has changed from 0 to 1. An input whose enable bit is 0 never sets the flag.
- R5: A read strobe at address 2 returns the flag's present value in that cycle and clears the flag at the following edge.
- R6: When a set condition and a clearing read fall in the same cycle, the flag ends up at 1.
- R7: Setting an enable bit while its input is already high sets the flag. Clearing that enable bit and setting it again sets the flag again.
- R8: With FILTER_EN=1, an input change reaches the detector only after it has held for FILTER_CYCLES consecutive clocks. The flag then rises FILTER_CYCLES+1 edges after the change, and shorter pulses are ignored.
- R9: irq is high exactly when the flag is 1.
- R10: Reset sets the flag, irq and the enable register to 0.
- R11: A read at address 3 returns 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_in | input | NUM_KEYS | Key input levels, synchronous to clk |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read at address 2 clears the flag |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data for the selected register, combinational |
| irq | output | 1 | Interrupt request, equal to the flag |

## Verification
The assertions check on every cycle that the flag rises only after a detected enabled rise. They also check that a clearing read with no set condition drops the flag, that a set condition always leaves the flag at 1 even during a read, that the enable register changes only on a write to it, and that the debounce stage only ever adopts a level seen on the previous cycle. Only the bench scenarios can show the things that depend on a sequence of events: the flag rising again when a held-high input is masked and then unmasked, the register map and its reserved bits, writes that are ignored, reset clearing a set flag, and the exact edge at which a debounced input sets the flag while short pulses are dropped.

// File: rtl/kip_pkg.sv
package kip_pkg;

    localparam int KIP_AW       = 2;
    localparam int KIP_DW       = 4;
    localparam int KIP_FLAG_BIT = 2;

    typedef enum logic [KIP_AW-1:0] {
        REG_LEVEL  = 2'd0,
        REG_MASK   = 2'd1,
        REG_FACTOR = 2'd2,
        REG_SPARE  = 2'd3
    } kip_reg_e;

    typedef logic [KIP_DW-1:0] kip_word_t;

    typedef struct packed {
        logic      rd;
        logic      wr;
        kip_reg_e  sel;
        kip_word_t wdata;
    } kip_bus_t;

    function automatic kip_word_t factor_word(input logic flag);
        kip_word_t w;
        w = '0;
        w[KIP_FLAG_BIT] = flag;
        return w;
    endfunction

    function automatic logic bus_hit(input kip_bus_t b, input kip_reg_e r, input logic want_wr);
        return (want_wr ? b.wr : b.rd) && (b.sel == r);
    endfunction

endpackage

// File: rtl/kip_filter.sv
module kip_filter
    import kip_pkg::*;
#(
    parameter int NUM_KEYS      = 4,
    parameter bit FILTER_EN     = 1'b1,
    parameter int FILTER_CYCLES = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_KEYS-1:0] raw_i,
    output logic [NUM_KEYS-1:0] filt_o
);

    localparam int CNT_W = $clog2(FILTER_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FILTER_CYCLES - 1);

    generate
        if (FILTER_EN) begin : g_filter
            for (genvar i = 0; i < NUM_KEYS; i++) begin : g_bit
                logic [CNT_W-1:0] cnt_q;
                logic             stab_q;

                always_ff @(posedge clk) begin
                    if (rst) begin
                        cnt_q  <= '0;
                        stab_q <= 1'b0;
                    end else if (raw_i[i] == stab_q) begin
                        cnt_q  <= '0;
                    end else if (cnt_q == LAST) begin
                        stab_q <= raw_i[i];
                        cnt_q  <= '0;
                    end else begin
                        cnt_q  <= cnt_q + 1'b1;
                    end
                end

                assign filt_o[i] = stab_q;

                // R8: the stable level only ever takes a value the pin held one cycle earlier
                p_filter_adopts_raw_r8: assert property (@(posedge clk) disable iff (rst)
                    (!$stable(stab_q) && !$past(rst)) |-> (stab_q == $past(raw_i[i])));
            end
        end else begin : g_bypass
            assign filt_o = raw_i;
        end
    endgenerate

endmodule

// File: rtl/kip_edge_flag.sv
module kip_edge_flag
    import kip_pkg::*;
#(
    parameter int NUM_KEYS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_KEYS-1:0] level_i,
    input  logic [NUM_KEYS-1:0] enable_i,
    input  logic                clr_i,
    output logic                flag_o
);

    logic [NUM_KEYS-1:0] gated;
    logic [NUM_KEYS-1:0] prev_q;
    logic                set_evt;
    logic                flag_q;

    assign gated   = level_i & enable_i;
    assign set_evt = |(gated & ~prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            flag_q <= 1'b0;
        end else begin
            prev_q <= gated;
            if (set_evt) begin
                flag_q <= 1'b1;
            end else if (clr_i) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign flag_o = flag_q;

    // R4: the flag rises only after a detected enabled rise
    p_rise_needs_event_r4: assert property (@(posedge clk) disable iff (rst)
        ($rose(flag_q) && !$past(rst)) |-> $past(set_evt));

    // R5: a clearing read with no competing event drops the flag
    p_read_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_evt) |=> !flag_q);

    // R6: an event wins over a simultaneous clearing read
    p_event_wins_r6: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> flag_q);

endmodule

// File: rtl/kip_regs.sv
module kip_regs
    import kip_pkg::*;
#(
    parameter int NUM_KEYS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  kip_bus_t            bus_i,
    input  logic [NUM_KEYS-1:0] raw_i,
    input  logic                flag_i,
    output logic [NUM_KEYS-1:0] enable_o,
    output kip_word_t           rdata_o,
    output logic                clr_o
);

    logic [NUM_KEYS-1:0] en_q;
    logic                mask_wr;
    kip_word_t           raw_w;
    kip_word_t           en_w;

    assign mask_wr = bus_hit(bus_i, REG_MASK, 1'b1);
    assign clr_o   = bus_hit(bus_i, REG_FACTOR, 1'b0);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (mask_wr) begin
            en_q <= bus_i.wdata[NUM_KEYS-1:0];
        end
    end

    assign enable_o = en_q;

    always_comb begin
        raw_w = '0;
        raw_w[NUM_KEYS-1:0] = raw_i;
        en_w = '0;
        en_w[NUM_KEYS-1:0] = en_q;
    end

    always_comb begin
        unique case (bus_i.sel)
            REG_LEVEL:  rdata_o = raw_w;
            REG_MASK:   rdata_o = en_w;
            REG_FACTOR: rdata_o = factor_word(flag_i);
            default:    rdata_o = '0;
        endcase
    end

    // R2: the enable register changes only through a write to its address
    p_mask_write_only_r2: assert property (@(posedge clk) disable iff (rst)
        (!$stable(en_q) && !$past(rst)) |-> $past(mask_wr));

endmodule

// File: rtl/keyirq_unit.sv
module keyirq_unit
    import kip_pkg::*;
#(
    parameter int NUM_KEYS      = 4,
    parameter bit FILTER_EN     = 1'b1,
    parameter int FILTER_CYCLES = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_KEYS-1:0] key_in,
    input  logic [KIP_AW-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [KIP_DW-1:0]   bus_wdata,
    output logic [KIP_DW-1:0]   bus_rdata,
    output logic                irq
);

    kip_bus_t            bus;
    logic [NUM_KEYS-1:0] filt;
    logic [NUM_KEYS-1:0] enable;
    logic                clr;
    logic                flag;

    assign bus = '{rd: bus_rd, wr: bus_wr, sel: kip_reg_e'(bus_addr), wdata: bus_wdata};

    kip_filter #(
        .NUM_KEYS      (NUM_KEYS),
        .FILTER_EN     (FILTER_EN),
        .FILTER_CYCLES (FILTER_CYCLES)
    ) u_filter (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (key_in),
        .filt_o (filt)
    );

    kip_regs #(
        .NUM_KEYS (NUM_KEYS)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .bus_i    (bus),
        .raw_i    (key_in),
        .flag_i   (flag),
        .enable_o (enable),
        .rdata_o  (bus_rdata),
        .clr_o    (clr)
    );

    kip_edge_flag #(
        .NUM_KEYS (NUM_KEYS)
    ) u_edge (
        .clk      (clk),
        .rst      (rst),
        .level_i  (filt),
        .enable_i (enable),
        .clr_i    (clr),
        .flag_o   (flag)
    );

    assign irq = flag;

endmodule

// File: tb/keyirq_unit_tb_top.sv
module keyirq_unit_tb_top;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [1:0] addr;
        logic [3:0] wdata;
        logic [3:0] keys;
        logic [3:0] exp;
        logic       exp_irq;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 27;
    // fields: wr, rd, addr, wdata, keys, expected rdata, expected irq, requirement
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 2'd0, 4'h0, 4'b0000, 4'b0000, 1'b0, 4'd1},  // R1 level read
        '{1'b0, 1'b1, 2'd0, 4'h0, 4'b1010, 4'b1010, 1'b0, 4'd1},  // R1 pattern
        '{1'b1, 1'b0, 2'd0, 4'hF, 4'b1010, 4'b1010, 1'b0, 4'd1},  // R1 write attempt
        '{1'b0, 1'b1, 2'd0, 4'h0, 4'b1010, 4'b1010, 1'b0, 4'd1},  // R1 write ignored
        '{1'b0, 1'b1, 2'd1, 4'h0, 4'b0000, 4'b0000, 1'b0, 4'd2},  // R2 reset value
        '{1'b1, 1'b0, 2'd1, 4'h1, 4'b0000, 4'b0000, 1'b0, 4'd2},  // R2 write 0001
        '{1'b0, 1'b1, 2'd1, 4'h0, 4'b0000, 4'b0001, 1'b0, 4'd2},  // R2 readback
        '{1'b0, 1'b0, 2'd2, 4'h0, 4'b0001, 4'b0000, 1'b0, 4'd4},  // R4 enabled rise
        '{1'b0, 1'b1, 2'd2, 4'h0, 4'b0001, 4'b0100, 1'b1, 4'd5},  // R5 read sees flag
        '{1'b0, 1'b1, 2'd2, 4'h0, 4'b0001, 4'b0000, 1'b0, 4'd5},  // R5 cleared
        '{1'b0, 1'b0, 2'd2, 4'h0, 4'b0011, 4'b0000, 1'b0, 4'd4},  // R4 masked rise
        '{1'b0, 1'b1, 2'd2, 4'h0, 4'b0011, 4'b0000, 1'b0, 4'd4},  // R4 no flag
        '{1'b0, 1'b0, 2'd2, 4'h0, 4'b0010, 4'b0000, 1'b0, 4'd4},  // R4 fall, no flag
        '{1'b0, 1'b1, 2'd2, 4'h0, 4'b0011, 4'b0000, 1'b0, 4'd6},  // R6 rise with read
        '{1'b0, 1'b0, 2'd2, 4'h0, 4'b0011, 4'b0100, 1'b1, 4'd6},  // R6 event kept
        '{1'b0, 1'b1, 2'd2, 4'h0, 4'b0011, 4'b0100, 1'b1, 4'd9},  // R9 irq with flag
        '{1'b1, 1'b0, 2'd1, 4'h3, 4'b0011, 4'b0001, 1'b0, 4'd7},  // R7 enable held-high bit
        '{1'b0, 1'b0, 2'd2, 4'h0, 4'b0011, 4'b0000, 1'b0, 4'd7},  // R7 event pending
        '{1'b0, 1'b1, 2'd2, 4'h0, 4'b0011, 4'b0100, 1'b1, 4'd7},  // R7 flag set
        '{1'b1, 1'b0, 2'd1, 4'h1, 4'b0011, 4'b0011, 1'b0, 4'd7},  // R7 mask bit 1
        '{1'b1, 1'b0, 2'd1, 4'h3, 4'b0011, 4'b0001, 1'b0, 4'd7},  // R7 unmask bit 1
        '{1'b0, 1'b0, 2'd2, 4'h0, 4'b0011, 4'b0000, 1'b0, 4'd7},  // R7 event pending
        '{1'b0, 1'b1, 2'd2, 4'h0, 4'b0011, 4'b0100, 1'b1, 4'd7},  // R7 flag raised again
        '{1'b0, 1'b1, 2'd3, 4'h0, 4'b0011, 4'b0000, 1'b0, 4'd11}, // R11 spare reads 0
        '{1'b1, 1'b0, 2'd2, 4'hF, 4'b0011, 4'b0000, 1'b0, 4'd3},  // R3 write attempt
        '{1'b0, 1'b1, 2'd2, 4'h0, 4'b0011, 4'b0000, 1'b0, 4'd3},  // R3 write ignored
        '{1'b0, 1'b1, 2'd0, 4'h0, 4'b0000, 4'b0000, 1'b0, 4'd1}   // R1 all low
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] n_keys = '0, n_wdata = '0, n_rdata;
    logic [1:0] n_addr = '0;
    logic       n_wr = 1'b0, n_rd = 1'b0, n_irq;
    logic [3:0] f_keys = '0, f_wdata = '0, f_rdata;
    logic [1:0] f_addr = '0;
    logic       f_wr = 1'b0, f_rd = 1'b0, f_irq;
    int         n_checks = 0;
    int         n_fails  = 0;
    bit         done     = 1'b0;

    always #5 clk = ~clk;

    keyirq_unit #(.NUM_KEYS(4), .FILTER_EN(1'b1), .FILTER_CYCLES(16)) dut_i (
        .clk(clk), .rst(rst), .key_in(f_keys), .bus_addr(f_addr), .bus_wr(f_wr),
        .bus_rd(f_rd), .bus_wdata(f_wdata), .bus_rdata(f_rdata), .irq(f_irq));

    keyirq_unit #(.NUM_KEYS(4), .FILTER_EN(1'b0), .FILTER_CYCLES(16)) dut_nf_i (
        .clk(clk), .rst(rst), .key_in(n_keys), .bus_addr(n_addr), .bus_wr(n_wr),
        .bus_rd(n_rd), .bus_wdata(n_wdata), .bus_rdata(n_rdata), .irq(n_irq));

    task automatic check(input logic [4:0] act, input logic [4:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got rdata=%b irq=%b, expected rdata=%b irq=%b",
                     req, act[4:1], act[0], exp[4:1], exp[0]);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10: reset state on both instances
        n_addr = 2'd1; f_addr = 2'd2; #1;
        check({n_rdata, n_irq}, {4'b0000, 1'b0}, "R10 mask after reset");
        check({f_rdata, f_irq}, {4'b0000, 1'b0}, "R10 flag after reset");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            n_wr = VECS[i].wr; n_rd = VECS[i].rd; n_addr = VECS[i].addr;
            n_wdata = VECS[i].wdata; n_keys = VECS[i].keys;
            #1;
            check({n_rdata, n_irq}, {VECS[i].exp, VECS[i].exp_irq},
                  $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R10: a set flag is cleared by reset
        @(negedge clk);
        n_wr = 1'b0; n_rd = 1'b0; n_addr = 2'd2; n_keys = 4'b0001;
        @(negedge clk); #1;
        check({n_rdata, n_irq}, {4'b0100, 1'b1}, "R10 flag set before reset");
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0; #1;
        check({n_rdata, n_irq}, {4'b0000, 1'b0}, "R10 flag cleared by reset");
        n_addr = 2'd1; #1;
        check({n_rdata, n_irq}, {4'b0000, 1'b0}, "R10 mask cleared by reset");

        // R8: filtered instance, short pulse ignored
        @(negedge clk);
        f_wr = 1'b1; f_addr = 2'd1; f_wdata = 4'h1;
        @(negedge clk);
        f_wr = 1'b0; f_addr = 2'd0; f_keys = 4'b0001; #1;
        check({f_rdata, f_irq}, {4'b0001, 1'b0}, "R1 raw level before filter");
        repeat (10) @(negedge clk);
        f_keys = 4'b0000;
        repeat (30) @(negedge clk);
        f_addr = 2'd2; #1;
        check({f_rdata, f_irq}, {4'b0000, 1'b0}, "R8 short pulse ignored");

        // R8: held level sets flag FILTER_CYCLES+1 edges after the change
        f_keys = 4'b0001;
        for (int k = 1; k <= 17; k++) begin
            @(negedge clk); #1;
            if (k == 16) check({f_rdata, f_irq}, {4'b0000, 1'b0}, "R8 not yet at edge 16");
            if (k == 17) check({f_rdata, f_irq}, {4'b0100, 1'b1}, "R8 flag at edge 17");
        end
        f_rd = 1'b1;
        @(negedge clk);
        f_rd = 1'b0; #1;
        check({f_rdata, f_irq}, {4'b0000, 1'b0}, "R5 filtered flag cleared by read");

        done = 1'b1;
        finish_run();
    end

endmodule